// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block sits next to a small 8-bit processor core and chooses among five interrupt sources. It tells the core that an interrupt is waiting and gives the restart address the core should jump to. The sources are a non-maskable line, three maskable restart levels (high, middle, low) and one general maskable request, whose vector is supplied by the external device rather than by this block.

The core controls the block through single-cycle command strobes. There are set and clear commands for a global enable, and a write command for a three-bit mask with one bit per restart level. At an instruction boundary, the core accepts whichever request is shown by pulsing `core_take`. Accepting a maskable source turns the global enable off. Accepting the general request arms an active-low acknowledge, which replaces the read strobe on the next instruction fetch so that the device can drive its opcode.

The high restart level is edge-captured into a pending flag. The middle, low and general sources follow their input levels. The non-maskable line is serviced once for each rising edge, and only while the line stays high.

Top module: `irq_vector_arbiter`

## Requirements
- R1: At most one source is chosen at a time. The fixed priority order, highest first, is non-maskable, high restart, middle restart, low restart, general request. `irq_req` is high exactly when some source is eligible.
- R2: A pending non-maskable request is eligible whatever the state of the global enable and mask bits. Its vector is 0x0024.
- R3: The restart vectors are 0x003C (high), 0x0034 (middle) and 0x002C (low), which is the level number times 8 plus 4. When the general request is chosen, `irq_ext` is 1 and `irq_vec` is 0. Otherwise `irq_ext` is 0.
- R4: A rising edge on `edge_in` sets the high-level pending flag even while that level is masked. The flag stays set after the input falls, until that level is accepted or `pend_clr` is pulsed.
- R5: The middle and low levels are eligible while their input is high, the global enable is 1 and their mask bit is 0. The general request needs only its input high and the global enable at 1. Mask bit positions in `mask_data`: bit 2 high level, bit 1 middle, bit 0 low. A 1 blocks the level.
- R6: The non-maskable source becomes pending on a rising edge of `nmi_in`. The pending state is lost if the line falls before it is accepted. After acceptance it does not request again until a new rising edge.
- R7: Acceptance happens on a clock edge where `core_take` and `irq_req` are both 1. Accepting a maskable source clears the global enable. Accepting the non-maskable source leaves the enable as it was.
- R8: `ie_set`, `ie_clr` and `mask_wr` take effect from the next cycle. `ie_clr` wins over `ie_set`. An acceptance of a maskable source in the same cycle as `ie_set` leaves the enable cleared.
- R9: After a general request is accepted, `ext_ack_n` is 0 during the first cycle in which `fetch_strobe` is 1, and it is 1 at all other times.
- R10: Reset clears the global enable, sets all three mask bits and clears every pending flag and the acknowledge, so no source except a new non-maskable edge can request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nmi_in | input | 1 | Non-maskable request line |
| edge_in | input | 1 | High restart level, edge-captured |
| mid_in | input | 1 | Middle restart level, level-sensitive |
| low_in | input | 1 | Low restart level, level-sensitive |
| gen_in | input | 1 | General request, level-sensitive |
| ie_set | input | 1 | Command: set global enable |
| ie_clr | input | 1 | Command: clear global enable |
| mask_wr | input | 1 | Command: load mask bits |
| mask_data | input | 3 | Mask value (bit2 high, bit1 middle, bit0 low) |
| pend_clr | input | 1 | Command: clear high-level pending flag |
| core_take | input | 1 | Core accepts the shown request |
| fetch_strobe | input | 1 | Core instruction-fetch read strobe |
| irq_req | output | 1 | Interrupt waiting for the core |
| irq_vec | output | VEC_W | Restart address of the chosen source |
| irq_ext | output | 1 | Chosen source is the general request |
| ext_ack_n | output | 1 | Active-low acknowledge for the general request |

## Verification
The main sweep resets the block for every combination of global enable, the three mask bits and the 32 patterns of simultaneous requests. After each reset it compares `irq_req`, `irq_vec` and `irq_ext` with a reference encoder in the bench. It then accepts the request and checks what remains. This separates a wrong priority order, a mask bit wired to the wrong level, an enable that fails to gate, and an acceptance that clears the wrong state.

Directed sequences cover the rest. One drops the non-maskable line before service. One latches a high-level edge under mask and exposes it later. One issues conflicting enable commands. One pulses the acknowledge once, and also strobes a fetch with nothing accepted.

// File: rtl/irqv_pkg.sv
package irqv_pkg;

  localparam int NUM_SRC = 5;
  localparam int MASK_W  = 3;

  // source slots, index order is priority order (0 = highest)
  localparam int IDX_NMI  = 0;
  localparam int IDX_EDGE = 1;
  localparam int IDX_MID  = 2;
  localparam int IDX_LOW  = 3;
  localparam int IDX_GEN  = 4;

  // mask bit positions
  localparam int MB_EDGE = 2;
  localparam int MB_MID  = 1;
  localparam int MB_LOW  = 0;

  localparam int SLOT_BYTES = 8;

  // restart level number of a source (0 for the general request)
  function automatic int level_of(int idx);
    case (idx)
      IDX_NMI:  return 4;
      IDX_EDGE: return 7;
      IDX_MID:  return 6;
      IDX_LOW:  return 5;
      default:  return 0;
    endcase
  endfunction

  // vector = (level + one half) * slot size, done in half steps
  function automatic logic [15:0] src_vector(int idx);
    int lvl;
    lvl = level_of(idx);
    if (lvl == 0) return 16'h0000;
    return 16'(((2 * lvl + 1) * SLOT_BYTES) / 2);
  endfunction

endpackage

// File: rtl/irqv_rise_hold.sv
module irqv_rise_hold #(
  parameter bit LEVEL_QUAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic clr,
  output logic armed
);

  logic din_q;
  logic pend_q;
  logic rise;
  logic pend_d;

  assign rise = din & ~din_q;

  always_comb begin
    if (rise)     pend_d = 1'b1;
    else if (clr) pend_d = 1'b0;
    else          pend_d = pend_q;
    if (LEVEL_QUAL) pend_d = pend_d & din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      din_q  <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      din_q  <= din;
      pend_q <= pend_d;
    end
  end

  generate
    if (LEVEL_QUAL) begin : g_qual
      assign armed = pend_q & din;
    end else begin : g_hold
      assign armed = pend_q;
    end
  endgenerate

  AST_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !clr && (!LEVEL_QUAL || din)) |=> pend_q); // R4

endmodule

// File: rtl/irqv_ctrl_regs.sv
module irqv_ctrl_regs
  import irqv_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ie_set,
  input  logic              ie_clr,
  input  logic              mask_wr,
  input  logic [MASK_W-1:0] mask_data,
  input  logic              accept_maskable,
  output logic              ie_q,
  output logic [MASK_W-1:0] mask_q
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ie_q   <= 1'b0;
      mask_q <= '1;
    end else begin
      if (accept_maskable || ie_clr) ie_q <= 1'b0;
      else if (ie_set)               ie_q <= 1'b1;
      if (mask_wr) mask_q <= mask_data;
    end
  end

  AST_IE_CLR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    ie_clr |=> !ie_q); // R8

  AST_MASK_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    mask_wr |=> (mask_q == $past(mask_data))); // R8

endmodule

// File: rtl/irqv_prio_pick.sv
module irqv_prio_pick #(
  parameter int N = 5
) (
  input  logic [N-1:0] elig,
  output logic [N-1:0] grant
);

  // lowest index wins
  always_comb begin
    grant = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (elig[i]) begin
        grant    = '0;
        grant[i] = 1'b1;
      end
    end
  end

endmodule

// File: rtl/irq_vector_arbiter.sv
module irq_vector_arbiter
  import irqv_pkg::*;
#(
  parameter int VEC_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nmi_in,
  input  logic              edge_in,
  input  logic              mid_in,
  input  logic              low_in,
  input  logic              gen_in,
  input  logic              ie_set,
  input  logic              ie_clr,
  input  logic              mask_wr,
  input  logic [MASK_W-1:0] mask_data,
  input  logic              pend_clr,
  input  logic              core_take,
  input  logic              fetch_strobe,
  output logic              irq_req,
  output logic [VEC_W-1:0]  irq_vec,
  output logic              irq_ext,
  output logic              ext_ack_n
);

  logic              nmi_armed;
  logic              edge_armed;
  logic              ie_q;
  logic [MASK_W-1:0] mask_q;
  logic [NUM_SRC-1:0] elig;
  logic [NUM_SRC-1:0] grant;

  // named events for the assertions
  logic accept;
  logic accept_nmi;
  logic accept_edge;
  logic accept_gen;
  logic accept_maskable;
  logic ack_armed_q;

  irqv_rise_hold #(.LEVEL_QUAL(1'b1)) u_nmi_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (nmi_in),
    .clr   (accept_nmi),
    .armed (nmi_armed)
  );

  irqv_rise_hold #(.LEVEL_QUAL(1'b0)) u_edge_hold (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (edge_in),
    .clr   (accept_edge | pend_clr),
    .armed (edge_armed)
  );

  irqv_ctrl_regs u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .ie_set          (ie_set),
    .ie_clr          (ie_clr),
    .mask_wr         (mask_wr),
    .mask_data       (mask_data),
    .accept_maskable (accept_maskable),
    .ie_q            (ie_q),
    .mask_q          (mask_q)
  );

  always_comb begin
    elig           = '0;
    elig[IDX_NMI]  = nmi_armed;
    elig[IDX_EDGE] = ie_q & ~mask_q[MB_EDGE] & edge_armed;
    elig[IDX_MID]  = ie_q & ~mask_q[MB_MID]  & mid_in;
    elig[IDX_LOW]  = ie_q & ~mask_q[MB_LOW]  & low_in;
    elig[IDX_GEN]  = ie_q & gen_in;
  end

  irqv_prio_pick #(.N(NUM_SRC)) u_pick (
    .elig  (elig),
    .grant (grant)
  );

  always_comb begin
    irq_vec = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      if (grant[i]) irq_vec = VEC_W'(src_vector(i));
    end
  end

  assign irq_req = |grant;
  assign irq_ext = grant[IDX_GEN];

  assign accept          = core_take & irq_req;
  assign accept_nmi      = accept & grant[IDX_NMI];
  assign accept_edge     = accept & grant[IDX_EDGE];
  assign accept_gen      = accept & grant[IDX_GEN];
  assign accept_maskable = accept & ~grant[IDX_NMI];

  always_ff @(posedge clk) begin
    if (!rst_n)            ack_armed_q <= 1'b0;
    else if (accept_gen)   ack_armed_q <= 1'b1;
    else if (fetch_strobe) ack_armed_q <= 1'b0;
  end

  assign ext_ack_n = ~(ack_armed_q & fetch_strobe);

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && ((|grant) == (|elig))); // R1

  AST_NMI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_armed |-> (irq_req && !irq_ext && irq_vec == VEC_W'(16'h0024))); // R2

  AST_ACCEPT_CLEARS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !grant[IDX_NMI]) |=> !ie_q); // R7

  AST_NMI_KEEPS_IE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_nmi && ie_q && !ie_clr) |=> ie_q); // R7

  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_ack_n |=> ext_ack_n); // R9

endmodule

// File: tb/irq_vector_arbiter_bench.sv
module irq_vector_arbiter_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        nmi_in, edge_in, mid_in, low_in, gen_in;
  logic        ie_set, ie_clr, mask_wr, pend_clr, core_take, fetch_strobe;
  logic [2:0]  mask_data;
  logic        irq_req, irq_ext, ext_ack_n;
  logic [15:0] irq_vec;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // bench model
  bit       m_ie, m_nmi, m_edge;
  bit [2:0] m_mask;

  always #4 clk = ~clk;

  irq_vector_arbiter u_irq_vector_arbiter (
    .clk(clk), .rst_n(rst_n), .nmi_in(nmi_in), .edge_in(edge_in),
    .mid_in(mid_in), .low_in(low_in), .gen_in(gen_in),
    .ie_set(ie_set), .ie_clr(ie_clr), .mask_wr(mask_wr),
    .mask_data(mask_data), .pend_clr(pend_clr), .core_take(core_take),
    .fetch_strobe(fetch_strobe), .irq_req(irq_req), .irq_vec(irq_vec),
    .irq_ext(irq_ext), .ext_ack_n(ext_ack_n)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference encoder: 0 nmi, 1 high, 2 mid, 3 low, 4 general, 5 none
  function automatic int ref_pick();
    if (m_nmi && nmi_in)                        return 0;
    if (m_ie && !m_mask[2] && m_edge)           return 1;
    if (m_ie && !m_mask[1] && mid_in)           return 2;
    if (m_ie && !m_mask[0] && low_in)           return 3;
    if (m_ie && gen_in)                         return 4;
    return 5;
  endfunction

  function automatic int ref_vec(int w);
    case (w)
      0: return 4 * 8 + 4;
      1: return 7 * 8 + 4;
      2: return 6 * 8 + 4;
      3: return 5 * 8 + 4;
      default: return 0;
    endcase
  endfunction

  task automatic cmp_outputs(input string req);
    int w;
    w = ref_pick();
    chk({req, " irq_req"}, int'(irq_req), int'(w != 5));
    chk({req, " irq_vec"}, int'(irq_vec), ref_vec(w));
    chk({req, " irq_ext"}, int'(irq_ext), int'(w == 4));
  endtask

  task automatic idle_inputs();
    nmi_in = 0; edge_in = 0; mid_in = 0; low_in = 0; gen_in = 0;
    ie_set = 0; ie_clr = 0; mask_wr = 0; mask_data = 3'b000;
    pend_clr = 0; core_take = 0; fetch_strobe = 0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    idle_inputs();
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_ie = 0; m_mask = 3'b111; m_nmi = 0; m_edge = 0;
  endtask

  task automatic setup(input bit ie, input bit [2:0] mk);
    ie_set = ie; mask_wr = 1'b1; mask_data = mk;
    @(negedge clk);
    ie_set = 0; mask_wr = 0;
    m_ie = ie; m_mask = mk;
  endtask

  task automatic take();
    int w;
    w = ref_pick();
    core_take = 1'b1;
    @(negedge clk);
    core_take = 1'b0;
    if (w == 0) m_nmi = 0;
    else if (w != 5) m_ie = 0;
    if (w == 1) m_edge = 0;
  endtask

  initial begin
    rst_n = 1'b0;
    idle_inputs();

    // ---------- R10: reset state ----------
    do_reset();
    chk("R10 ack idle", int'(ext_ack_n), 1);
    mid_in = 1; low_in = 1; gen_in = 1; edge_in = 1;
    @(negedge clk);
    chk("R10 masked after reset", int'(irq_req), 0);
    fetch_strobe = 1'b1; #1;
    chk("R9 no ack without accept", int'(ext_ack_n), 1);
    @(negedge clk);
    fetch_strobe = 1'b0;

    // ---------- sweep: R1 R2 R3 R5 R7 R9 ----------
    for (int ie = 0; ie < 2; ie++) begin
      for (int mk = 0; mk < 8; mk++) begin
        for (int pat = 0; pat < 32; pat++) begin
          int w;
          do_reset();
          setup(bit'(ie), 3'(mk));
          nmi_in = pat[0]; edge_in = pat[1]; mid_in = pat[2];
          low_in = pat[3]; gen_in = pat[4];
          @(negedge clk);
          m_nmi = pat[0]; m_edge = pat[1];
          cmp_outputs("R1 R2 R3 R5 pick");
          w = ref_pick();
          take();
          cmp_outputs("R6 R7 after accept");
          if (w == 4) begin
            chk("R9 ack waits for fetch", int'(ext_ack_n), 1);
            fetch_strobe = 1'b1; #1;
            chk("R9 ack on fetch", int'(ext_ack_n), 0);
            @(negedge clk);
            #1;
            chk("R9 ack one fetch only", int'(ext_ack_n), 1);
            fetch_strobe = 1'b0;
          end
        end
      end
    end

    // ---------- R6: non-maskable drops before service ----------
    do_reset();
    nmi_in = 1'b1;
    @(negedge clk);
    chk("R6 nmi pending", int'(irq_vec), 16'h0024);
    nmi_in = 1'b0; #1;
    chk("R6 nmi lost on fall", int'(irq_req), 0);
    @(negedge clk);
    nmi_in = 1'b1;
    @(negedge clk);
    chk("R6 nmi new edge", int'(irq_req), 1);
    take();
    @(negedge clk);
    chk("R6 no repeat while held", int'(irq_req), 0);

    // ---------- R4: edge latched under mask, then cleared ----------
    do_reset();
    setup(1'b1, 3'b111);
    edge_in = 1'b1;
    @(negedge clk);
    edge_in = 1'b0;
    @(negedge clk);
    chk("R4 masked edge hidden", int'(irq_req), 0);
    setup(1'b0, 3'b011);
    chk("R4 latched edge shows", int'(irq_vec), 16'h003C);
    pend_clr = 1'b1;
    @(negedge clk);
    pend_clr = 1'b0;
    chk("R4 pend_clr drops it", int'(irq_req), 0);

    // ---------- R5: level follows input ----------
    do_reset();
    setup(1'b1, 3'b000);
    mid_in = 1'b1; #1;
    chk("R5 mid level", int'(irq_vec), 16'h0034);
    mid_in = 1'b0; #1;
    chk("R5 mid released", int'(irq_req), 0);

    // ---------- R8: command conflicts ----------
    do_reset();
    gen_in = 1'b1;
    ie_set = 1'b1; ie_clr = 1'b1;
    @(negedge clk);
    ie_set = 1'b0; ie_clr = 1'b0;
    chk("R8 clear wins", int'(irq_req), 0);
    ie_set = 1'b1;
    @(negedge clk);
    ie_set = 1'b0;
    chk("R8 set applies", int'(irq_ext), 1);
    core_take = 1'b1; ie_set = 1'b1;
    @(negedge clk);
    core_take = 1'b0; ie_set = 1'b0;
    chk("R8 R7 accept beats set", int'(irq_req), 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule